// File: doc/BRIEF.md
# Legal Bus Disconnect Detector

This block holds the instruction sequencer until a target has left a parallel peripheral bus in a legal way. The sequencer issues a start command when it reaches a wait-for-disconnect step. The block then waits for a received message byte that announces the end of the connection: either a completion code or a disconnect code. Only after such a byte has arrived does it begin to time the bus. The bus is free when both the active-low busy line and the active-low select line are high.

The free period must last without a break for at least the bus-free delay. The block turns that delay into a clock-cycle count, rounding up from the clock frequency parameter. Any return of either line to the active level during the window restarts the count from zero. A bus-free period that comes before the qualifying message does not count toward the window.

When the window has run out, the block gives a one-cycle done pulse and returns to idle. A further message strobe during the window is a protocol violation. It raises a one-cycle error pulse and restarts the timing.

Top module: `bus_disconnect_detector`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, done_o and proto_err_o are low and the block is idle. A reset during a window cancels the window.
- R2: In idle, message bytes and bus-free time have no effect. Only a start_i strobe moves the block to wait for a message.
- R3: While the block waits for a message, a strobe on msg_vld_i with byte 0x00 (completion) or 0x04 (disconnect) arms the bus-free timing. Any other byte value is ignored.
- R4: The bus counts as free only when both bsy_n_i and sel_n_i are high. While either line is low, no done pulse can occur.
- R5: The window is ceil(BUS_FREE_NS * CLK_FREQ_HZ / 1e9) consecutive free cycles, which is 50 at 125 MHz. When the bus is already free, done_o rises in the cycle after the 50th clock edge that follows the arming edge.
- R6: If either bus line goes low during the window, the count restarts from zero once that low level reaches the synchroniser output.
- R7: Bus-free time before the arming message is not counted. The window starts at the arming edge even if the bus was free long before it.
- R8: Each bus line passes through a two-stage synchroniser. A line released before clock edge E0 is first counted at edge E0+2, so done_o follows 52 edges after the release.
- R9: done_o is high for exactly one cycle, and the block is then idle. Later message bytes give no done pulse until a new start_i arrives.
- R10: A msg_vld_i strobe during the window raises proto_err_o for one cycle, starting in the next cycle. It also restarts the window from zero. This holds even on the edge where the window would have expired, and in that case no done pulse is given.
- R11: start_i is ignored while the block is not idle. A start strobe during the window does not change when done_o occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Sequencer command to begin waiting for a disconnect |
| bsy_n_i | input | 1 | Bus busy line, active low, asynchronous to clk |
| sel_n_i | input | 1 | Bus select line, active low, asynchronous to clk |
| msg_vld_i | input | 1 | One-cycle strobe: a message byte has been received |
| msg_byte_i | input | 8 | Received message byte, valid with msg_vld_i |
| done_o | output | 1 | One-cycle pulse: legal disconnect complete |
| proto_err_o | output | 1 | One-cycle pulse: message strobe arrived inside the bus-free window |

## Verification
Window expiry and the protocol-error path can fall on the same clock edge. The bench arms the window, waits 49 edges, and then places a second message strobe on the 50th edge, the one on which expiry would occur. It then requires proto_err_o high and done_o low in the following cycle. It also requires done_o to appear exactly 50 edges after that strobe, which shows that the error path won and restarted the count. Bus-line glitches and start strobes inside the window are judged by the same exact done timing.

// File: rtl/bdd_pkg.sv
`timescale 1ns/1ps
package bdd_pkg;
   typedef enum logic [1:0] {
      ST_IDLE      = 2'd0,
      ST_WAIT_MSG  = 2'd1,
      ST_WAIT_FREE = 2'd2
   } bdd_state_e;

   // Cycles needed so that cycles * period >= window; never rounds down.
   function automatic int free_cycles(longint win_ns, longint clk_hz);
      longint prod;
      prod = win_ns * clk_hz;
      return int'((prod + 64'd999_999_999) / 64'd1_000_000_000);
   endfunction
endpackage

// File: rtl/bdd_sync.sv
`timescale 1ns/1ps
module bdd_sync #(
   parameter int               WIDTH  = 2,
   parameter int               STAGES = 2,
   parameter logic [WIDTH-1:0] INIT   = '1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d_i,
   output logic [WIDTH-1:0] q_o
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("bdd_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0][WIDTH-1:0] chain_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= {STAGES{INIT}};
      else        chain_q <= {chain_q[STAGES-2:0], d_i};
   end

   assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/bdd_msg_match.sv
`timescale 1ns/1ps
module bdd_msg_match #(
   parameter int                 MSG_W     = 8,
   parameter int                 NUM_CODES = 2,
   parameter logic [MSG_W-1:0]   CODES [NUM_CODES] = '{8'h00, 8'h04}
) (
   input  logic             vld_i,
   input  logic [MSG_W-1:0] byte_i,
   output logic             qual_o
);
   generate
      if (NUM_CODES < 1) begin : g_bad_codes
         $error("bdd_msg_match: NUM_CODES must be at least 1");
      end
   endgenerate

   logic [NUM_CODES-1:0] hit;

   genvar g;
   generate
      for (g = 0; g < NUM_CODES; g++) begin : g_cmp
         assign hit[g] = (byte_i == CODES[g]);
      end
   endgenerate

   assign qual_o = vld_i && (|hit);
endmodule

// File: rtl/bdd_free_timer.sv
`timescale 1ns/1ps
module bdd_free_timer #(
   parameter int LIMIT = 50,
   parameter int CW    = $clog2(LIMIT + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          run_i,
   input  logic          restart_i,
   output logic          expire_o,
   output logic [CW-1:0] cnt_o
);
   generate
      if (LIMIT < 1) begin : g_bad_limit
         $error("bdd_free_timer: LIMIT must be at least 1");
      end
   endgenerate

   localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

   logic [CW-1:0] cnt_q;

   assign expire_o = run_i && !restart_i && (cnt_q == LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                             cnt_q <= '0;
      else if (!run_i || restart_i || expire_o) cnt_q <= '0;
      else                                    cnt_q <= cnt_q + 1'b1;
   end

   assign cnt_o = cnt_q;
endmodule

// File: rtl/bdd_ctrl.sv
`timescale 1ns/1ps
module bdd_ctrl
   import bdd_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       start_i,
   input  logic       qual_i,
   input  logic       msg_vld_i,
   input  logic       expire_i,
   output bdd_state_e state_o,
   output logic       run_o,
   output logic       done_o,
   output logic       err_o
);
   bdd_state_e st_q, st_d;
   logic       done_d, err_d;

   always_comb begin
      st_d   = st_q;
      done_d = 1'b0;
      err_d  = 1'b0;
      unique case (st_q)
         ST_IDLE:      if (start_i) st_d = ST_WAIT_MSG;
         ST_WAIT_MSG:  if (qual_i)  st_d = ST_WAIT_FREE;
         ST_WAIT_FREE: begin
            if (msg_vld_i) begin
               err_d = 1'b1;
            end else if (expire_i) begin
               done_d = 1'b1;
               st_d   = ST_IDLE;
            end
         end
         default:      st_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= ST_IDLE;
         done_o <= 1'b0;
         err_o  <= 1'b0;
      end else begin
         st_q   <= st_d;
         done_o <= done_d;
         err_o  <= err_d;
      end
   end

   assign state_o = st_q;
   assign run_o   = (st_q == ST_WAIT_FREE);
endmodule

// File: rtl/bus_disconnect_detector.sv
`timescale 1ns/1ps
module bus_disconnect_detector
   import bdd_pkg::*;
#(
   parameter int               CLK_FREQ_HZ   = 125_000_000,
   parameter int               BUS_FREE_NS   = 400,
   parameter int               SYNC_STAGES   = 2,
   parameter int               MSG_W         = 8,
   parameter logic [MSG_W-1:0] CMD_DONE_CODE = 8'h00,
   parameter logic [MSG_W-1:0] DISC_CODE     = 8'h04
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   input  logic             bsy_n_i,
   input  logic             sel_n_i,
   input  logic             msg_vld_i,
   input  logic [MSG_W-1:0] msg_byte_i,
   output logic             done_o,
   output logic             proto_err_o
);
   localparam int FREE_CYC = free_cycles(longint'(BUS_FREE_NS), longint'(CLK_FREQ_HZ));
   localparam int CNT_W    = $clog2(FREE_CYC + 1);
   localparam logic [MSG_W-1:0] CODES [2] = '{CMD_DONE_CODE, DISC_CODE};

   generate
      if (CLK_FREQ_HZ < 1 || BUS_FREE_NS < 1) begin : g_bad_time
         $error("bus_disconnect_detector: clock and window must be positive");
      end
      if (MSG_W < 1) begin : g_bad_msg
         $error("bus_disconnect_detector: MSG_W must be positive");
      end
   endgenerate

   logic [1:0]       bus_s;
   logic             bus_free;
   logic             qual;
   logic             run;
   logic             restart;
   logic             expire;
   logic [CNT_W-1:0] cnt;
   bdd_state_e       st;

   bdd_sync #(.WIDTH(2), .STAGES(SYNC_STAGES), .INIT(2'b11)) u_sync (
      .clk(clk), .rst_n(rst_n), .d_i({bsy_n_i, sel_n_i}), .q_o(bus_s)
   );

   assign bus_free = &bus_s;
   assign restart  = !bus_free || msg_vld_i;

   bdd_msg_match #(.MSG_W(MSG_W), .NUM_CODES(2), .CODES(CODES)) u_match (
      .vld_i(msg_vld_i), .byte_i(msg_byte_i), .qual_o(qual)
   );

   bdd_free_timer #(.LIMIT(FREE_CYC), .CW(CNT_W)) u_timer (
      .clk(clk), .rst_n(rst_n), .run_i(run), .restart_i(restart),
      .expire_o(expire), .cnt_o(cnt)
   );

   bdd_ctrl u_ctrl (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .qual_i(qual),
      .msg_vld_i(msg_vld_i), .expire_i(expire), .state_o(st),
      .run_o(run), .done_o(done_o), .err_o(proto_err_o)
   );
endmodule

// File: rtl/bdd_checker.sv
`timescale 1ns/1ps
module bdd_checker
   import bdd_pkg::*;
#(
   parameter int LIMIT = 50,
   parameter int CW    = 6
) (
   input logic          clk,
   input logic          rst_n,
   input logic          start_i,
   input logic          msg_vld_i,
   input logic          done_o,
   input logic          proto_err_o,
   input bdd_state_e    st,
   input logic          qual,
   input logic          bus_free,
   input logic [CW-1:0] cnt
);
   a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);

   a_r9_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> st == ST_IDLE);

   a_r10_err_single: assert property (@(posedge clk) disable iff (!rst_n)
      proto_err_o |=> !proto_err_o);

   a_r10_err_excl: assert property (@(posedge clk) disable iff (!rst_n)
      !(done_o && proto_err_o));

   a_r10_err_restart: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_WAIT_FREE && msg_vld_i) |=> (proto_err_o && cnt == '0));

   a_r3_arm: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_WAIT_MSG && qual) |=> st == ST_WAIT_FREE);

   a_r6_restart: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_WAIT_FREE && !bus_free) |=> cnt == '0);

   a_r5_full_window: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> $past(cnt) == CW'(LIMIT - 1));

   a_r2_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_IDLE && !start_i) |=> st == ST_IDLE);

   a_r7_no_count_early: assert property (@(posedge clk) disable iff (!rst_n)
      (st != ST_WAIT_FREE) |=> cnt == '0);
endmodule

bind bus_disconnect_detector bdd_checker #(.LIMIT(FREE_CYC), .CW(CNT_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .start_i(start_i), .msg_vld_i(msg_vld_i),
   .done_o(done_o), .proto_err_o(proto_err_o), .st(st), .qual(qual),
   .bus_free(bus_free), .cnt(cnt)
);

// File: tb/tb_bus_disconnect_detector.sv
`timescale 1ns/1ps
module tb_bus_disconnect_detector;
   localparam int PERIOD_NS = 8;
   localparam int WIN       = (400 + PERIOD_NS - 1) / PERIOD_NS;  // 50
   localparam int NVEC      = 6;
   // {message byte, done expected}
   localparam logic [8:0] VEC [NVEC] = '{
      {8'h04, 1'b1}, {8'h01, 1'b0}, {8'h00, 1'b1},
      {8'hFF, 1'b0}, {8'h0C, 1'b0}, {8'h04, 1'b1}
   };

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       start_i = 1'b0;
   logic       bsy_n_i = 1'b1;
   logic       sel_n_i = 1'b1;
   logic       msg_vld_i = 1'b0;
   logic [7:0] msg_byte_i = 8'h00;
   logic       done_o, proto_err_o;

   int checks = 0;
   int failures = 0;
   bit finished = 1'b0;

   always #(PERIOD_NS / 2) clk = ~clk;

   bus_disconnect_detector dut (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .bsy_n_i(bsy_n_i),
      .sel_n_i(sel_n_i), .msg_vld_i(msg_vld_i), .msg_byte_i(msg_byte_i),
      .done_o(done_o), .proto_err_o(proto_err_o)
   );

   task automatic check_bit(string req, string what, logic act, logic exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s %s: actual=%0b expected=%0b", req, what, act, exp);
      end
   endtask

   task automatic tick(int n);
      repeat (n) @(posedge clk);
      @(negedge clk);
   endtask

   task automatic quiet_for(int n, string req);
      bit seen = 1'b0;
      repeat (n) begin
         @(posedge clk);
         @(negedge clk);
         if (done_o) seen = 1'b1;
      end
      check_bit(req, "done seen in quiet span", seen, 1'b0);
   endtask

   task automatic pulse_start();
      start_i = 1'b1;
      tick(1);
      start_i = 1'b0;
   endtask

   // Drives a strobe across one edge (M); returns at the negedge after M.
   task automatic send_msg(logic [7:0] b);
      msg_vld_i  = 1'b1;
      msg_byte_i = b;
      tick(1);
      msg_vld_i  = 1'b0;
   endtask

   task automatic summary();
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
   endtask

   initial begin
      #(PERIOD_NS * 200000);
      if (!finished) begin
         failures++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         summary();
         $finish;
      end
   end

   initial begin
      tick(3);
      // R1: outputs low under reset
      check_bit("R1", "done in reset", done_o, 1'b0);
      check_bit("R1", "err in reset", proto_err_o, 1'b0);
      rst_n = 1'b1;
      tick(1);
      check_bit("R1", "done after reset", done_o, 1'b0);

      // R2: idle ignores messages and free bus
      send_msg(8'h04);
      quiet_for(WIN + 5, "R2");

      // Table: R3 codes, R5 exact window, R7 prior free time ignored
      for (int i = 0; i < NVEC; i++) begin
         pulse_start();
         tick(2);
         send_msg(VEC[i][8:1]);
         tick(WIN - 1);
         check_bit("R5", "done one edge early", done_o, 1'b0);
         tick(1);
         check_bit("R3", "done at window end", done_o, VEC[i][0]);
         if (VEC[i][0]) begin
            tick(1);
            check_bit("R9", "done one cycle only", done_o, 1'b0);
         end
      end

      // R4 and R8: one line active blocks done; release timing via synchroniser
      pulse_start();
      sel_n_i = 1'b0;
      tick(3);
      send_msg(8'h04);
      quiet_for(WIN + 5, "R4");
      sel_n_i = 1'b1;
      tick(WIN + 1);
      check_bit("R8", "done before sync latency", done_o, 1'b0);
      tick(1);
      check_bit("R8", "done after release", done_o, 1'b1);

      // R6: busy glitch inside window restarts count
      pulse_start();
      send_msg(8'h00);
      tick(20);
      bsy_n_i = 1'b0;
      tick(1);
      bsy_n_i = 1'b1;
      tick(WIN + 1);
      check_bit("R6", "done before restarted window", done_o, 1'b0);
      tick(1);
      check_bit("R6", "done after restarted window", done_o, 1'b1);

      // R10: message strobe mid-window
      pulse_start();
      send_msg(8'h00);
      tick(29);
      send_msg(8'h04);
      check_bit("R10", "err after strobe", proto_err_o, 1'b1);
      check_bit("R10", "no done with err", done_o, 1'b0);
      tick(1);
      check_bit("R10", "err one cycle", proto_err_o, 1'b0);
      tick(WIN - 2);
      check_bit("R10", "done before restarted window", done_o, 1'b0);
      tick(1);
      check_bit("R10", "done after restarted window", done_o, 1'b1);

      // R10: strobe on the expiry edge wins over done
      pulse_start();
      send_msg(8'h04);
      tick(WIN - 1);
      send_msg(8'h01);
      check_bit("R10", "err on expiry edge", proto_err_o, 1'b1);
      check_bit("R10", "done suppressed on expiry edge", done_o, 1'b0);
      tick(WIN - 1);
      check_bit("R10", "done early after collision", done_o, 1'b0);
      tick(1);
      check_bit("R10", "done after collision", done_o, 1'b1);

      // R11: start inside window ignored
      pulse_start();
      send_msg(8'h04);
      tick(9);
      pulse_start();
      tick(WIN - 11);
      check_bit("R11", "done early after extra start", done_o, 1'b0);
      tick(1);
      check_bit("R11", "done time unchanged", done_o, 1'b1);

      // R9: back in idle, message alone gives nothing
      send_msg(8'h04);
      quiet_for(WIN + 5, "R9");

      // R1: reset mid-window cancels it
      pulse_start();
      send_msg(8'h04);
      tick(10);
      rst_n = 1'b0;
      tick(1);
      check_bit("R1", "done in mid reset", done_o, 1'b0);
      check_bit("R1", "err in mid reset", proto_err_o, 1'b0);
      rst_n = 1'b1;
      tick(1);
      send_msg(8'h04);
      quiet_for(WIN + 5, "R1");

      finished = 1'b1;
      summary();
      $finish;
   end
endmodule